// File: doc/BRIEF.md
# Clock-Derived GCM Nonce Issuer

This block hands out 64-bit initialization vectors to an AES-GCM transmit engine. The values come from a free-running time counter rather than a per-message counter. The counter advances by one every `TICK_DIV` clocks. A packet transmitter raises a request, and the block answers with the current counter value as the IV. It never gives out a value that is not strictly above the IV it issued before. While the counter has not yet moved past that last value, the block holds its ready line low, so the transmitter waits.

Each security association is loaded with a strobe that carries a lifetime, given as a number of counter ticks. The block measures the ticks that pass after the load. Once the lifetime is reached, it marks the association expired and refuses to issue IVs for it. After reset no association is valid, so nothing can be sent until a fresh one is loaded. A request that cannot be served is consumed at once and marked with an error flag, and no IV is recorded for it. A reload does not clear the history of issued IVs, so IVs keep rising across rekeys.

Top module: `gcm_iv_sequencer`

## Requirements
- R1: After reset the time counter is 0. It increments by exactly 1 on every `TICK_DIV`-th rising clock edge with reset released. With the default `TICK_DIV` = 4, `iv_out` equals floor(n/4) after n such edges.
- R2: With a usable association, `req_ready` is low whenever the time counter is not strictly greater than the last issued IV. With `TICK_DIV` = 4, a request made one clock after a handshake waits for the next counter step.
- R3: Every IV accepted without error (`req_valid`, `req_ready` high and `err_out` low) is strictly greater than the previously accepted IV. When it is the first value after a stall, it is exactly the previous IV plus 1.
- R4: After reset `sa_active` and `sa_expired` are 0. A request then completes at once with `req_ready` = 1 and `err_out` = 1.
- R5: A one-clock `sa_load` pulse latches `sa_life` as the lifetime and takes the current counter as the lifetime base. On the next clock `sa_active` is 1 and `sa_expired` is 0.
- R6: Once the counter is `sa_life` or more ticks past the base, IV issue stops immediately and `sa_expired` rises one clock later. A lifetime of 0 expires right after the load.
- R7: While the association is expired, a request completes at once with `err_out` = 1 and is dropped. `sa_expired` stays 1 until the next load.
- R8: A load leaves the last-issued-IV record unchanged. A request right after a rekey stalls until the counter passes the IV issued before the rekey.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transmitter requests an IV |
| req_ready | output | 1 | Request completes this cycle |
| iv_out | output | 64 | Registered time counter, the IV on a good handshake |
| err_out | output | 1 | Request is answered with an error and dropped |
| sa_load | input | 1 | Load a new association (one-clock pulse) |
| sa_life | input | 32 | Lifetime in counter ticks, sampled on `sa_load` |
| sa_active | output | 1 | An association has been loaded since reset |
| sa_expired | output | 1 | The loaded association has outlived its lifetime |

## Verification
The assertions assume that `sa_load` is a single-clock pulse. They also assume the counter never wraps during a run, so a plain unsigned greater-than check on issued IVs is sound; with 64 bits this takes centuries of ticks, and the stimulus runs only a few hundred clocks. They assume inputs change only away from the rising edge. The bench drives every input on the falling edge and keeps `req_valid` high until the handshake completes.

// File: rtl/gcm_iv_pkg.sv
// Shared helpers for the clock-derived nonce issuer.
// Assumes unsigned counters; modular subtraction handles counter wrap.
package gcm_iv_pkg;

    // Ticks elapsed from base to now, modulo the counter width
    function automatic logic [63:0] ticks_since(input logic [63:0] now, input logic [63:0] base);
        return now - base;
    endfunction

endpackage

// File: rtl/gcm_iv_tick_timer.sv
// Free-running time counter: advances by one every TICK_DIV clocks.
// Assumes TICK_DIV >= 1; counter starts at zero on reset.
module gcm_iv_tick_timer #(
    parameter int CNT_W    = 64,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic step;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_q;
            // Prescaler: wraps at TICK_DIV-1 and signals a tick
            always_ff @(posedge clk) begin
                if (!rst_n)                               div_q <= '0;
                else if (div_q == DIV_W'(TICK_DIV - 1))   div_q <= '0;
                else                                      div_q <= div_q + 1'b1;
            end
            assign step = (div_q == DIV_W'(TICK_DIV - 1));
        end else begin : g_nodiv
            assign step = 1'b1;
        end
    endgenerate

    // Time counter: one increment per tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/gcm_iv_guard.sv
// Remembers the last issued IV and reports whether the counter is past it.
// Assumes issue is only raised when fresh is high.
module gcm_iv_guard #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             issue,
    output logic             fresh
);
    logic [CNT_W-1:0] last_q;

    // Last-issued record: kept across rekeys, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)     last_q <= '0;
        else if (issue) last_q <= cnt;
    end

    assign fresh = (cnt > last_q);
endmodule

// File: rtl/gcm_iv_sa_life.sv
// Association state: loaded flag, lifetime limit, base tick and expiry.
// Assumes load is a one-clock pulse; lifetime counts counter ticks.
module gcm_iv_sa_life #(
    parameter int CNT_W  = 64,
    parameter int LIFE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              load,
    input  logic [LIFE_W-1:0] life,
    output logic              active,
    output logic              expired,
    output logic              usable
);
    import gcm_iv_pkg::*;

    logic [CNT_W-1:0]  base_q;
    logic [LIFE_W-1:0] lim_q;
    logic [63:0]       elapsed;
    logic              over;

    assign elapsed = ticks_since(64'(cnt), 64'(base_q));
    assign over    = (elapsed >= 64'(lim_q));

    // Load captures limit and base; no association exists after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base_q <= '0;
            lim_q  <= '0;
        end else if (load) begin
            active <= 1'b1;
            base_q <= cnt;
            lim_q  <= life;
        end
    end

    // Sticky expiry flag: set once lifetime is used up, cleared by a load
    always_ff @(posedge clk) begin
        if (!rst_n)              expired <= 1'b0;
        else if (load)           expired <= 1'b0;
        else if (active && over) expired <= 1'b1;
    end

    assign usable = active && !expired && !over;
endmodule

// File: rtl/gcm_iv_sequencer.sv
// Top: issues strictly increasing time-based IVs under a lifetime-bounded
// association. A request stalls while the counter has not passed the last
// IV; an unusable association answers at once with an error and drops it.
// Assumes req_valid is held until req_ready.
module gcm_iv_sequencer #(
    parameter int CNT_W    = 64,
    parameter int LIFE_W   = 32,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    output logic [CNT_W-1:0]  iv_out,
    output logic              err_out,
    input  logic              sa_load,
    input  logic [LIFE_W-1:0] sa_life,
    output logic              sa_active,
    output logic              sa_expired
);
    logic [CNT_W-1:0] cnt;
    logic             fresh;
    logic             usable;
    logic             issue;

    gcm_iv_tick_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (cnt)
    );

    gcm_iv_sa_life #(.CNT_W(CNT_W), .LIFE_W(LIFE_W)) u_sa (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .load    (sa_load),
        .life    (sa_life),
        .active  (sa_active),
        .expired (sa_expired),
        .usable  (usable)
    );

    gcm_iv_guard #(.CNT_W(CNT_W)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .issue (issue),
        .fresh (fresh)
    );

    // Handshake: serve when usable and fresh, reject at once when unusable
    assign issue     = req_valid && usable && fresh;
    assign err_out   = req_valid && !usable;
    assign req_ready = !usable || fresh;
    assign iv_out    = cnt;
endmodule

// File: rtl/gcm_iv_sequencer_chk.sv
// Checker for the nonce issuer; bound to the top module below.
// Assumes sa_load is a one-clock pulse and the counter never wraps.
module gcm_iv_sequencer_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CNT_W-1:0] iv_out,
    input logic             err_out,
    input logic             sa_load,
    input logic             sa_active,
    input logic             sa_expired
);
    logic             ok_hs;
    logic             seen_q;
    logic [CNT_W-1:0] prev_q;

    assign ok_hs = req_valid && req_ready && !err_out;

    // Record of the last good handshake, kept independently of the design
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else if (ok_hs) begin
            seen_q <= 1'b1;
            prev_q <= iv_out;
        end
    end

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_out == $past(iv_out)) || (iv_out == $past(iv_out) + 1'b1));

    a_r2_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ok_hs) && $stable(iv_out)) |-> !ok_hs);

    a_r3_increasing: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_hs && seen_q) |-> (iv_out > prev_q));

    a_r4_inactive_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!sa_active && req_valid) |-> (err_out && req_ready));

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        sa_load |=> (sa_active && !sa_expired));

    a_r7_expired_err: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_expired && req_valid) |-> (err_out && req_ready));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sa_expired) && !$past(sa_load)) |-> sa_expired);
endmodule

bind gcm_iv_sequencer gcm_iv_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .iv_out     (iv_out),
    .err_out    (err_out),
    .sa_load    (sa_load),
    .sa_active  (sa_active),
    .sa_expired (sa_expired)
);

// File: tb/test_gcm_iv_sequencer.sv
`timescale 1ns/100ps
module test_gcm_iv_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] iv_out;
    logic        err_out;
    logic        sa_load = 1'b0;
    logic [31:0] sa_life = '0;
    logic        sa_active;
    logic        sa_expired;

    int errors = 0;
    int checks = 0;
    int edges  = 0;
    int cycles = 0;
    logic [63:0] last_iv = '0;

    always #2.5 clk = ~clk;

    gcm_iv_sequencer i_gcm_iv_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .iv_out(iv_out), .err_out(err_out), .sa_load(sa_load), .sa_life(sa_life),
        .sa_active(sa_active), .sa_expired(sa_expired)
    );

    // Bench model of elapsed clocks since reset release
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at a falling edge after the handshake
    task automatic do_req(output logic e, output logic [63:0] iv, output int stalls, output logic [63:0] exp_cnt);
        stalls = 0;
        req_valid = 1'b1;
        #1;
        while (!req_ready && stalls < 100) begin
            @(negedge clk); #1; stalls++;
        end
        e = err_out; iv = iv_out; exp_cnt = 64'(edges / 4);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_sa(input logic [31:0] life);
        sa_life = life; sa_load = 1'b1;
        @(negedge clk);
        sa_load = 1'b0;
    endtask

    task automatic align_tick();
        while ((edges % 4) != 0) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check("R4 active after reset", 64'(sa_active), 64'd0);
        check("R4 expired after reset", 64'(sa_expired), 64'd0);
        check("R1 counter after reset", iv_out, 64'(edges / 4));
    endtask

    task automatic t_no_sa();
        logic e; logic [63:0] iv, ex; int st;
        do_req(e, iv, st, ex);
        check("R4 error with no association", 64'(e), 64'd1);
        check("R4 no stall with no association", 64'(st), 64'd0);
    endtask

    task automatic t_first_issue();
        logic e; logic [63:0] iv, ex; int st;
        load_sa(32'd100);
        #1;
        check("R5 active after load", 64'(sa_active), 64'd1);
        check("R5 not expired after load", 64'(sa_expired), 64'd0);
        @(negedge clk);
        do_req(e, iv, st, ex);
        check("R1 IV equals tick count", iv, ex);
        check("R3 first IV no error", 64'(e), 64'd0);
        last_iv = iv;
    endtask

    task automatic t_stall();
        logic e; logic [63:0] iv, ex; int st;
        align_tick();
        do_req(e, iv, st, ex);
        check("R3 aligned IV above previous", 64'(iv > last_iv), 64'd1);
        last_iv = iv;
        do_req(e, iv, st, ex);
        check("R2 stall cycles after aligned handshake", 64'(st), 64'd3);
        check("R3 IV after stall is previous plus one", iv, last_iv + 64'd1);
        check("R1 IV after stall matches ticks", iv, ex);
        last_iv = iv;
        for (int k = 0; k < 4; k++) begin
            do_req(e, iv, st, ex);
            check("R3 repeated IV plus one", iv, last_iv + 64'd1);
            check("R3 repeated no error", 64'(e), 64'd0);
            last_iv = iv;
        end
    endtask

    task automatic t_rekey_keeps_last();
        logic e; logic [63:0] iv, ex; int st;
        align_tick();
        do_req(e, iv, st, ex);
        last_iv = iv;
        load_sa(32'd100);
        do_req(e, iv, st, ex);
        check("R8 stall after rekey", 64'(st), 64'd2);
        check("R8 IV after rekey above old", iv, last_iv + 64'd1);
        last_iv = iv;
    endtask

    task automatic t_expiry();
        logic e; logic [63:0] iv, ex; int st;
        load_sa(32'd5);
        repeat (11) @(negedge clk);
        #1;
        check("R6 not expired before lifetime", 64'(sa_expired), 64'd0);
        @(negedge clk);
        do_req(e, iv, st, ex);
        check("R6 IV issued within lifetime", 64'(e), 64'd0);
        check("R3 IV within lifetime rising", 64'(iv > last_iv), 64'd1);
        last_iv = iv;
        repeat (16) @(negedge clk);
        #1;
        check("R6 expired after lifetime", 64'(sa_expired), 64'd1);
        @(negedge clk);
        do_req(e, iv, st, ex);
        check("R7 expired request error", 64'(e), 64'd1);
        check("R7 expired request not stalled", 64'(st), 64'd0);
        #1;
        check("R7 expiry sticky", 64'(sa_expired), 64'd1);
    endtask

    task automatic t_reload_after_expiry();
        logic e; logic [63:0] iv, ex; int st;
        load_sa(32'd50);
        #1;
        check("R5 reload clears expiry", 64'(sa_expired), 64'd0);
        @(negedge clk);
        do_req(e, iv, st, ex);
        check("R8 IV after reload no error", 64'(e), 64'd0);
        check("R8 IV after reload rising", 64'(iv > last_iv), 64'd1);
        last_iv = iv;
    endtask

    task automatic t_zero_life();
        logic e; logic [63:0] iv, ex; int st;
        load_sa(32'd0);
        do_req(e, iv, st, ex);
        check("R6 zero lifetime request error", 64'(e), 64'd1);
        #1;
        check("R6 zero lifetime expired", 64'(sa_expired), 64'd1);
    endtask

    initial begin : watchdog
        wait (cycles >= 20000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_no_sa();
        t_first_issue();
        t_stall();
        t_rekey_keeps_last();
        t_expiry();
        t_reload_after_expiry();
        t_zero_life();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule